// File: doc/BRIEF.md
# Resident Thread-Block Activity Controller

This controller tracks the thread blocks resident on one GPU core. Two separate limits apply. The number of storage slots sets how many blocks may be resident at once. The scheduler limit sets how many of those blocks may be active at once. A launch request takes the lowest free slot. The new block starts active when there is room under the scheduler limit, and inactive otherwise.

Each cycle the controller looks at per-warp long-latency stall flags. When every warp of an active block is stalled, that block is demoted and a ready inactive block is promoted in its place. Both blocks stay resident, so a swap only changes an activity flag. No register or shared-memory contents are moved.

A completion pulse frees a slot. The active position it leaves behind is refilled from the ready inactive blocks. The warp scheduler reads the active mask. The launch logic reads the resident mask and the grant.

Top module: `cta_swap_ctrl`

## Requirements
- R1: When any slot is not resident, a `launch_req` sampled at a clock edge produces `launch_gnt` high for exactly the following cycle. `launch_slot` then holds the lowest non-resident slot index, and that slot's resident bit is set. When all slots are resident, no grant is given.
- R2: The number of set bits in `active_mask` never exceeds `ACT_MAX`. A launched block is made active only if the active count after that cycle's other updates is below `ACT_MAX`.
- R3: An active block is demoted only when all `WARPS` of its stall bits are set. The stall bit for warp w of slot s is `stall_i[s*WARPS+w]`.
- R4: When an active block is fully stalled and a ready inactive block exists, a swap takes place in the same update. The victim is the lowest-index fully stalled active slot. The replacement is the first ready inactive slot in round-robin order, starting after the slot promoted most recently (slot 0 first after reset). The swap shows on `active_mask` one cycle after the stall is sampled.
- R5: When no ready inactive block exists, a fully stalled active block stays active.
- R6: A `done_i` bit for a resident slot clears both its resident and active bits in the next cycle. A `done_i` bit for a non-resident slot has no effect.
- R7: At most one block goes from inactive to active per cycle, even when several positions free up or several active blocks are fully stalled.
- R8: Whenever the active count, after completions, is below `ACT_MAX`, one ready inactive block is promoted, chosen in the same round-robin order as in R4.
- R9: While `rst_n` is low, `active_mask`, `resident_mask` and `launch_gnt` are zero.
- R10: An inactive block is ready only if at least one of its warps is not stalled. A fully stalled inactive block is never promoted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_req | input | 1 | Request to place a new thread block |
| done_i | input | SLOTS | Per-slot completion pulse |
| stall_i | input | SLOTS*WARPS | Per-slot, per-warp long-latency stall flag |
| launch_gnt | output | 1 | One-cycle grant for an accepted launch |
| launch_slot | output | $clog2(SLOTS) | Slot given to the granted launch |
| active_mask | output | SLOTS | Blocks currently offered to the warp scheduler |
| resident_mask | output | SLOTS | Blocks currently holding on-chip storage |

## Verification
A wrong round-robin pointer or victim choice shows on `active_mask` one cycle after the stall pattern is applied: the wrong slot is promoted or demoted. For that reason the stimulus sequence always sets up two or more candidates before each swap. A miscounted active population shows up as soon as a launch or a refill pushes the mask past `ACT_MAX`, or holds it below the limit while ready blocks wait. A lost resident bit shows on the next grant, because the controller then hands out a slot that is still occupied or skips a free one.

// File: rtl/cta_swap_pkg.sv
package cta_swap_pkg;
  typedef enum logic [1:0] {
    PROMO_NONE = 2'd0,
    PROMO_FILL = 2'd1,
    PROMO_SWAP = 2'd2
  } promo_kind_e;
endpackage

// File: rtl/cta_stall_eval.sv
module cta_stall_eval #(
  parameter int SLOTS = 8,
  parameter int WARPS = 4
) (
  input  logic [SLOTS*WARPS-1:0] stall_vec,
  output logic [SLOTS-1:0]       all_stalled
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign all_stalled[s] = &stall_vec[s*WARPS +: WARPS];
  end
endmodule

// File: rtl/cta_low_pick.sv
module cta_low_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cta_rr_pick.sv
module cta_rr_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  int pos;
  always_comb begin
    found = 1'b0;
    idx   = last;
    pos   = 0;
    for (int off = 1; off <= N; off++) begin
      pos = int'(last) + off;
      if (pos >= N) pos = pos - N;
      if (!found && req[pos]) begin
        found = 1'b1;
        idx   = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/cta_swap_ctrl.sv
module cta_swap_ctrl
  import cta_swap_pkg::*;
#(
  parameter int SLOTS   = 8,
  parameter int ACT_MAX = 4,
  parameter int WARPS   = 4,
  localparam int IW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CW     = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch_req,
  input  logic [SLOTS-1:0]       done_i,
  input  logic [SLOTS*WARPS-1:0] stall_i,
  output logic                   launch_gnt,
  output logic [IW-1:0]          launch_slot,
  output logic [SLOTS-1:0]       active_mask,
  output logic [SLOTS-1:0]       resident_mask
);
  localparam logic [SLOTS-1:0] ONE_HOT0 = SLOTS'(1);
  localparam logic [CW-1:0]    LIMIT    = CW'(ACT_MAX);

  // registers
  logic [SLOTS-1:0] act_q, act_nxt;
  logic [SLOTS-1:0] res_q, res_nxt;
  logic [IW-1:0]    last_q, last_nxt;
  logic             last_en;
  logic             gnt_q, gnt_nxt;
  logic [IW-1:0]    gslot_q, gslot_nxt;
  logic             gslot_en;

  // combinational
  logic [SLOTS-1:0] all_stalled;
  logic [SLOTS-1:0] done_eff, act_kept, victim_req, ready_req, free_req;
  logic [SLOTS-1:0] act_mid;
  logic [CW-1:0]    kept_cnt, mid_cnt;
  logic             victim_found, cand_found, free_found, accept;
  logic [IW-1:0]    victim_idx, cand_idx, free_idx;
  promo_kind_e      promo;

  cta_stall_eval #(.SLOTS(SLOTS), .WARPS(WARPS)) u_eval (
    .stall_vec   (stall_i),
    .all_stalled (all_stalled)
  );

  assign done_eff   = done_i & res_q;
  assign act_kept   = act_q & ~done_eff;
  assign victim_req = act_kept & all_stalled;
  assign ready_req  = res_q & ~act_q & ~done_eff & ~all_stalled;
  assign free_req   = ~res_q;

  cta_low_pick #(.N(SLOTS)) u_victim (
    .req   (victim_req),
    .found (victim_found),
    .idx   (victim_idx)
  );

  cta_rr_pick #(.N(SLOTS)) u_cand (
    .req   (ready_req),
    .last  (last_q),
    .found (cand_found),
    .idx   (cand_idx)
  );

  cta_low_pick #(.N(SLOTS)) u_free (
    .req   (free_req),
    .found (free_found),
    .idx   (free_idx)
  );

  always_comb begin
    kept_cnt = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (act_kept[i]) kept_cnt = kept_cnt + CW'(1);
    end
  end

  // one promotion per cycle: refill has priority over a swap
  always_comb begin
    if (cand_found && (kept_cnt < LIMIT))      promo = PROMO_FILL;
    else if (cand_found && victim_found)       promo = PROMO_SWAP;
    else                                       promo = PROMO_NONE;
  end

  always_comb begin
    act_mid = act_kept;
    mid_cnt = kept_cnt;
    case (promo)
      PROMO_FILL: begin
        act_mid = act_kept | (ONE_HOT0 << cand_idx);
        mid_cnt = kept_cnt + CW'(1);
      end
      PROMO_SWAP: begin
        act_mid = (act_kept & ~(ONE_HOT0 << victim_idx)) | (ONE_HOT0 << cand_idx);
      end
      default: ;
    endcase
  end

  assign accept = launch_req && free_found;

  always_comb begin
    act_nxt   = act_mid;
    res_nxt   = res_q & ~done_eff;
    gnt_nxt   = accept;
    gslot_nxt = gslot_q;
    gslot_en  = accept;
    last_en   = (promo != PROMO_NONE);
    last_nxt  = cand_idx;
    if (accept) begin
      res_nxt   = res_nxt | (ONE_HOT0 << free_idx);
      gslot_nxt = free_idx;
      if (mid_cnt < LIMIT) act_nxt = act_mid | (ONE_HOT0 << free_idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      res_q   <= '0;
      last_q  <= IW'(SLOTS - 1);
      gnt_q   <= 1'b0;
      gslot_q <= '0;
    end else begin
      act_q <= act_nxt;
      res_q <= res_nxt;
      gnt_q <= gnt_nxt;
      if (last_en)  last_q  <= last_nxt;
      if (gslot_en) gslot_q <= gslot_nxt;
    end
  end

  assign active_mask   = act_q;
  assign resident_mask = res_q;
  assign launch_gnt    = gnt_q;
  assign launch_slot   = gslot_q;
endmodule

// File: rtl/cta_swap_ctrl_chk.sv
module cta_swap_ctrl_chk #(
  parameter int SLOTS   = 8,
  parameter int ACT_MAX = 4,
  parameter int WARPS   = 4,
  localparam int IW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [SLOTS-1:0]       done_i,
  input logic [SLOTS*WARPS-1:0] stall_i,
  input logic                   launch_gnt,
  input logic [IW-1:0]          launch_slot,
  input logic [SLOTS-1:0]       active_mask,
  input logic [SLOTS-1:0]       resident_mask
);
  logic [SLOTS-1:0] res_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_d <= '0;
    else        res_d <= resident_mask;
  end

  // R2
  active_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active_mask) <= ACT_MAX);

  // R6
  active_resident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mask & ~resident_mask) == '0);

  // R1
  grant_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_gnt |-> (resident_mask[launch_slot] && !res_d[launch_slot]));

  // R7
  one_promotion_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active_mask & ~$past(active_mask) & $past(resident_mask)) <= 1);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    // R3
    demote_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(active_mask[s]) && !active_mask[s] && resident_mask[s])
        |-> $past(&stall_i[s*WARPS +: WARPS]));

    // R10
    promote_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(resident_mask[s] && !active_mask[s]) && active_mask[s])
        |-> !$past(&stall_i[s*WARPS +: WARPS]));

    // R6
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done_i[s] && resident_mask[s]) |-> !resident_mask[s]);
  end
endmodule

bind cta_swap_ctrl cta_swap_ctrl_chk #(
  .SLOTS(SLOTS), .ACT_MAX(ACT_MAX), .WARPS(WARPS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .done_i(done_i), .stall_i(stall_i),
  .launch_gnt(launch_gnt), .launch_slot(launch_slot),
  .active_mask(active_mask), .resident_mask(resident_mask)
);

// File: tb/cta_swap_ctrl_tb_top.sv
module cta_swap_ctrl_tb_top;
  localparam int SLOTS = 8;
  localparam int ACT_MAX = 4;
  localparam int WARPS = 4;
  localparam int NV = 20;

  logic clk, rst_n, launch_req;
  logic [SLOTS-1:0] done_i;
  logic [SLOTS*WARPS-1:0] stall_i;
  logic launch_gnt;
  logic [2:0] launch_slot;
  logic [SLOTS-1:0] active_mask, resident_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  cta_swap_ctrl #(.SLOTS(SLOTS), .ACT_MAX(ACT_MAX), .WARPS(WARPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .launch_req(launch_req), .done_i(done_i),
    .stall_i(stall_i), .launch_gnt(launch_gnt), .launch_slot(launch_slot),
    .active_mask(active_mask), .resident_mask(resident_mask)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {launch, done[8], stall[32], exp_active[8], exp_resident[8], exp_gnt, exp_slot[3]}
  localparam logic [60:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h00000000, 8'h01, 8'h01, 1'b1, 3'd0},
    {1'b1, 8'h00, 32'h00000000, 8'h03, 8'h03, 1'b1, 3'd1},
    {1'b1, 8'h00, 32'h00000000, 8'h07, 8'h07, 1'b1, 3'd2},
    {1'b1, 8'h00, 32'h00000000, 8'h0F, 8'h0F, 1'b1, 3'd3},
    {1'b1, 8'h00, 32'h00000000, 8'h0F, 8'h1F, 1'b1, 3'd4},
    {1'b1, 8'h00, 32'h00000000, 8'h0F, 8'h3F, 1'b1, 3'd5},
    {1'b0, 8'h00, 32'h000000F0, 8'h1D, 8'h3F, 1'b0, 3'd0},
    {1'b0, 8'h00, 32'h000000F0, 8'h1D, 8'h3F, 1'b0, 3'd0},
    {1'b0, 8'h00, 32'h0000007F, 8'h3C, 8'h3F, 1'b0, 3'd0},
    {1'b0, 8'h00, 32'h00000FFF, 8'h3C, 8'h3F, 1'b0, 3'd0},
    {1'b0, 8'h08, 32'h00000000, 8'h35, 8'h37, 1'b0, 3'd0},
    {1'b1, 8'h00, 32'h00000000, 8'h35, 8'h3F, 1'b1, 3'd3},
    {1'b0, 8'h00, 32'h000F0F00, 8'h33, 8'h3F, 1'b0, 3'd0},
    {1'b0, 8'h00, 32'h000F0F00, 8'h2B, 8'h3F, 1'b0, 3'd0},
    {1'b1, 8'h00, 32'h00000000, 8'h2B, 8'h7F, 1'b1, 3'd6},
    {1'b1, 8'h00, 32'h00000000, 8'h2B, 8'hFF, 1'b1, 3'd7},
    {1'b1, 8'h00, 32'h00000000, 8'h2B, 8'hFF, 1'b0, 3'd0},
    {1'b0, 8'h03, 32'h00000000, 8'h38, 8'hFC, 1'b0, 3'd0},
    {1'b0, 8'h00, 32'h00000000, 8'h78, 8'hFC, 1'b0, 3'd0},
    {1'b0, 8'h00, 32'h00000000, 8'h78, 8'hFC, 1'b0, 3'd0}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 2, 3, 4, 5:  return "R1";
      6, 8:              return "R4";
      7:                 return "R10";
      9:                 return "R5";
      10:                return "R6";
      11, 19:            return "R2";
      12, 17:            return "R7";
      13:                return "R3";
      14, 15, 16:        return "R1";
      default:           return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    launch_req = 1'b0;
    done_i = '0;
    stall_i = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "active_mask", 32'(active_mask), 32'h0);
    check("R9", "resident_mask", 32'(resident_mask), 32'h0);
    check("R9", "launch_gnt", 32'(launch_gnt), 32'h0);
    rst_n = 1'b1;

    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      launch_req = VEC[i][60];
      done_i     = VEC[i][59:52];
      stall_i    = VEC[i][51:20];
      @(negedge clk);
      check(tag_of(i), $sformatf("step %0d active_mask", i), 32'(active_mask), 32'(VEC[i][19:12]));
      check(tag_of(i), $sformatf("step %0d resident_mask", i), 32'(resident_mask), 32'(VEC[i][11:4]));
      check(tag_of(i), $sformatf("step %0d launch_gnt", i), 32'(launch_gnt), 32'(VEC[i][3]));
      if (VEC[i][3])
        check(tag_of(i), $sformatf("step %0d launch_slot", i), 32'(launch_slot), 32'(VEC[i][2:0]));
    end
    launch_req = 1'b0;
    done_i = '0;
    stall_i = '0;

    // R9: asynchronous reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9", "active_mask in reset", 32'(active_mask), 32'h0);
    check("R9", "resident_mask in reset", 32'(resident_mask), 32'h0);
    check("R9", "launch_gnt in reset", 32'(launch_gnt), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: fresh launch goes to slot 0, active
    @(negedge clk);
    launch_req = 1'b1;
    @(negedge clk);
    launch_req = 1'b0;
    check("R1", "launch_gnt after reset", 32'(launch_gnt), 32'h1);
    check("R1", "launch_slot after reset", 32'(launch_slot), 32'h0);
    check("R2", "active after reset launch", 32'(active_mask), 32'h01);
    // R1: grant lasts one cycle; R6: done for an empty slot is ignored
    done_i = 8'h80;
    @(negedge clk);
    done_i = '0;
    check("R1", "launch_gnt one cycle", 32'(launch_gnt), 32'h0);
    check("R6", "resident after stray done", 32'(resident_mask), 32'h01);
    check("R6", "active after stray done", 32'(active_mask), 32'h01);
    // R5: lone stalled block with no replacement stays active
    stall_i = 32'h0000000F;
    @(negedge clk);
    @(negedge clk);
    stall_i = '0;
    check("R5", "lone stalled block", 32'(active_mask), 32'h01);

    finish_run();
  end
endmodule